// File: doc/BRIEF.md
# Serial-Output Conversion Frame Sequencer

This block is the digital front of a successive-approximation converter that an SPI master reads with clock polarity 0 and phase 0. It samples an active-low select line and the serial clock into its own system clock domain, follows the position within the read frame, and tells the analog side when the sampling window closes. At that point it captures a 14-bit result and two sub-bits from a parallel stand-in port, then shifts out a frame of 24 positions: zero padding first, the result most significant bit first, then the sub-bits. Any further clocks produce zeros.

Releasing the select line, at any time, ends the frame, clears the position counter and the shift state, turns the data driver off and enters shutdown. A new frame is accepted only after the select line has been high for a minimum number of system clocks. The data output and its enable are separate ports, so that a tri-state pad can be placed at the chip edge.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, and whenever the synchronized select is high, `sleep` is 1, `dout_oe` is 0 and `dout` is 0.
- R2: An accepted falling edge of `cs_n` sets `dout_oe` to 1 with `dout` at 0 and clears `sleep`.
- R3: `hold_strobe` is a single-cycle pulse produced on the 6th falling edge of `sclk` in a frame, exactly once per frame.
- R4: Frame position k (sampled by the master at rising edge k of `sclk`, driven after falling edge k-1) carries 0 for k = 1..8, `conv_word` bit 13 down to bit 0 for k = 9..22, `conv_sub` bit 1 at k = 23 and `conv_sub` bit 0 at k = 24.
- R5: While the driver is on, `dout` changes only in response to a falling edge of `sclk`.
- R6: Falling edges beyond the 24th keep `dout` at 0 for as long as `cs_n` stays low, and produce no further `hold_strobe`.
- R7: Raising `cs_n` in the middle of a frame enters shutdown; the next accepted frame starts again from position 1 with a freshly captured word.
- R8: A falling edge of `cs_n` is accepted only if the synchronized select was high for at least `MIN_CS_HIGH` system clocks (default 4); otherwise the block stays in shutdown with the driver off until `cs_n` rises again.
- R9: The word and sub-bits are captured at the `hold_strobe` point; later changes of `conv_word` or `conv_sub` do not alter the frame.
- R10: A change on `cs_n` or `sclk` affects the outputs after the third rising edge of `clk` (two synchronizer stages and one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the master, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| conv_word | input | 14 | Conversion result from the stand-in port |
| conv_sub | input | 2 | Sub-bits from the stand-in port |
| dout | output | 1 | Serial data toward the pad |
| dout_oe | output | 1 | Pad driver enable (0 means high impedance) |
| hold_strobe | output | 1 | One-cycle pulse when the sampling window closes |
| sleep | output | 1 | 1 while in shutdown |

## Verification
The bench builds the block with its defaults: a 14-bit word, two sub-bits, eight padding positions, the hold at edge 6, two synchronizer stages and a four-cycle minimum select-high time, and it runs the serial clock at eight system clocks per period. These values keep a whole frame plus trailing clocks to a few hundred cycles, so full frames with all-ones, all-zeros and mixed words, an abort at edge 10, and a select-high pulse of two cycles (below the four-cycle limit) all fit in one short run. A behavioural model with the three-edge latency is compared on every clock, and a master task reassembles each frame from the rising-edge samples.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned WORD_BITS_DEF  = 14;
  localparam int unsigned SUB_BITS_DEF   = 2;
  localparam int unsigned PAD_BITS_DEF   = 8;
  localparam int unsigned HOLD_AT_DEF    = 6;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned MIN_HIGH_DEF   = 4;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_cs_guard.sv
module sar_cs_guard
  import sar_seq_pkg::*;
#(
  parameter int unsigned MIN_HIGH = MIN_HIGH_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic cs_fall,
  output logic start
);
  localparam int unsigned HW = cnt_width(MIN_HIGH);
  localparam logic [HW-1:0] LIMIT = HW'(MIN_HIGH);

  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst)                    high_cnt <= LIMIT;
    else if (!cs_s)             high_cnt <= '0;
    else if (high_cnt < LIMIT)  high_cnt <= high_cnt + 1'b1;
  end

  assign start = cs_fall && (high_cnt >= LIMIT);
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl #(
  parameter int unsigned FRAME_LEN = 24,
  parameter int unsigned PAD_BITS  = 8,
  parameter int unsigned HOLD_AT   = 6,
  parameter int unsigned CNT_W     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic start,
  input  logic sclk_fall,
  output logic load,
  output logic shift,
  output logic hold_strobe
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] HOLD_PRE = CNT_W'(HOLD_AT - 1);
  localparam logic [CNT_W-1:0] DATA_PRE = CNT_W'(PAD_BITS - 1);

  logic             active;
  logic [CNT_W-1:0] edge_cnt;
  logic             step;

  assign step  = active && sclk_fall && !cs_s && !start;
  assign load  = step && (edge_cnt == HOLD_PRE);
  assign shift = step && (edge_cnt >= DATA_PRE);

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      active      <= 1'b0;
      edge_cnt    <= '0;
      hold_strobe <= 1'b0;
    end else if (start) begin
      active      <= 1'b1;
      edge_cnt    <= '0;
      hold_strobe <= 1'b0;
    end else begin
      hold_strobe <= load;
      if (step && edge_cnt != LAST) edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              start,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              dout,
  output logic              dout_oe
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      sreg    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (start) begin
      sreg    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b1;
    end else if (load) begin
      sreg <= word;
    end else if (shift) begin
      dout <= sreg[WORD_W-1];
      sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = WORD_BITS_DEF,
  parameter int unsigned SUB_W       = SUB_BITS_DEF,
  parameter int unsigned PAD_BITS    = PAD_BITS_DEF,
  parameter int unsigned HOLD_AT     = HOLD_AT_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF,
  parameter int unsigned MIN_CS_HIGH = MIN_HIGH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] conv_word,
  input  logic [SUB_W-1:0]  conv_sub,
  output logic              dout,
  output logic              dout_oe,
  output logic              hold_strobe,
  output logic              sleep
);
  localparam int unsigned WORD_W    = DATA_W + SUB_W;
  localparam int unsigned FRAME_LEN = PAD_BITS + WORD_W;
  localparam int unsigned CNT_W     = cnt_width(FRAME_LEN);

  logic cs_s, sclk_s, cs_d, sclk_d;
  logic cs_fall, sclk_fall, start, load, shift;

  sar_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk (clk), .rst (rst), .d ({sclk, cs_n}), .q ({sclk_s, cs_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = cs_d && !cs_s;
  assign sclk_fall = sclk_d && !sclk_s;

  sar_cs_guard #(.MIN_HIGH(MIN_CS_HIGH)) u_guard (
    .clk (clk), .rst (rst), .cs_s (cs_s), .cs_fall (cs_fall), .start (start)
  );

  sar_frame_ctl #(
    .FRAME_LEN (FRAME_LEN), .PAD_BITS (PAD_BITS),
    .HOLD_AT (HOLD_AT), .CNT_W (CNT_W)
  ) u_ctl (
    .clk (clk), .rst (rst), .cs_s (cs_s), .start (start),
    .sclk_fall (sclk_fall), .load (load), .shift (shift),
    .hold_strobe (hold_strobe)
  );

  sar_shift_out #(.WORD_W(WORD_W)) u_out (
    .clk (clk), .rst (rst), .cs_s (cs_s), .start (start),
    .load (load), .shift (shift), .word ({conv_word, conv_sub}),
    .dout (dout), .dout_oe (dout_oe)
  );

  always_ff @(posedge clk) begin
    if (rst || cs_s) sleep <= 1'b1;
    else if (start)  sleep <= 1'b0;
  end
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic dout,
  input logic dout_oe,
  input logic hold_strobe,
  input logic sleep
);
  // R1: shutdown means the pad driver is off
  a_r1_quiet_in_sleep: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_oe);

  // R2: the driver turns on at a low level
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> !dout);

  // R3: the hold strobe lasts one cycle
  a_r3_hold_single: assert property (@(posedge clk) disable iff (rst)
    hold_strobe |=> !hold_strobe);

  // R4: the hold point falls inside the zero padding of a live frame
  a_r4_pad_at_hold: assert property (@(posedge clk) disable iff (rst)
    hold_strobe |-> (dout_oe && !dout));

  // R5: a data change traces back to a falling serial clock three edges earlier
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(dout_oe) && (dout != $past(dout)))
      |-> (!$past(sclk, 3) && $past(sclk, 4)));

  // R7: a select held high reaches shutdown after the pipeline delay
  a_r7_cs_high_sleeps: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 3) |-> (sleep && !dout_oe));
endmodule

bind sar_serial_seq sar_serial_seq_chk u_chk (
  .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .dout (dout),
  .dout_oe (dout_oe), .hold_strobe (hold_strobe), .sleep (sleep)
);

// File: tb/tb_sar_serial_seq.sv
module tb_sar_serial_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 4;
  localparam int MIN   = 4;
  localparam int HOLD  = 6;
  localparam int LEAD  = 8;
  localparam int WORD  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [13:0] conv_word = '0;
  logic [1:0]  conv_sub = '0;
  logic dout, dout_oe, hold_strobe, sleep;

  int checks = 0;
  int errs = 0;
  int hold_cnt = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // reference model state
  bit h_cs [4];
  bit h_sk [4];
  bit m_act, m_dout, m_oe, m_sleep, m_hold;
  int m_edges, m_high;
  logic [WORD-1:0] m_word;

  sar_serial_seq dut (
    .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk),
    .conv_word (conv_word), .conv_sub (conv_sub),
    .dout (dout), .dout_oe (dout_oe), .hold_strobe (hold_strobe),
    .sleep (sleep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R10: model sees pins after two sync stages and reacts on the third edge
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin h_cs[k] = 1'b1; h_sk[k] = 1'b0; end
      m_act = 0; m_edges = 0; m_word = '0; m_dout = 0; m_oe = 0;
      m_sleep = 1; m_hold = 0; m_high = MIN;
    end else begin
      for (int k = 3; k > 0; k--) begin h_cs[k] = h_cs[k-1]; h_sk[k] = h_sk[k-1]; end
      h_cs[0] = cs_n; h_sk[0] = sclk;
      m_hold = 0;
      if (h_cs[2]) begin
        m_act = 0; m_oe = 0; m_dout = 0; m_sleep = 1;
        if (m_high < MIN) m_high++;
      end else begin
        if (h_cs[3] && m_high >= MIN) begin
          m_act = 1; m_edges = 0; m_oe = 1; m_dout = 0; m_sleep = 0;
        end else if (m_act && h_sk[3] && !h_sk[2]) begin
          m_edges++;
          if (m_edges == HOLD) begin m_word = {conv_word, conv_sub}; m_hold = 1; end
          if (m_edges >= LEAD && m_edges < LEAD + WORD)
            m_dout = m_word[WORD-1-(m_edges-LEAD)];
          else
            m_dout = 0;
        end
        m_high = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R4", "dout vs model", dout, m_dout);
      chk("R2", "dout_oe vs model", dout_oe, m_oe);
      chk("R1", "sleep vs model", sleep, m_sleep);
      chk("R3", "hold_strobe vs model", hold_strobe, m_hold);
    end
    if (!rst && hold_strobe) hold_cnt++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master read: dout sampled just before each rising sclk
  task automatic read_frame(input logic [13:0] w, input logic [1:0] s,
                            input int nclk, output logic [31:0] got);
    got = '0;
    conv_word = w; conv_sub = s;
    @(negedge clk); cs_n = 1'b0;
    idle(4);
    chk("R2", "oe after select fall", dout_oe, 1);
    chk("R2", "dout after select fall", dout, 0);
    chk("R1", "sleep cleared", sleep, 0);
    for (int i = 0; i < nclk; i++) begin
      got = {got[30:0], dout};
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
      idle(HALF);
      if (i == 7) begin conv_word = ~w; conv_sub = ~s; end // R9 disturbance
    end
    cs_n = 1'b1;
    idle(MIN + 4);
  endtask

  task automatic full_frame(input logic [13:0] w, input logic [1:0] s);
    logic [31:0] got;
    int h0;
    h0 = hold_cnt;
    read_frame(w, s, 28, got);
    chk("R4", "frame bits", int'(got[27:4]), int'({8'h00, w, s}));
    chk("R6", "trailing zeros", int'(got[3:0]), 0);
    chk("R9", "word held", int'(got[19:4]), int'({w, s}));
    chk("R3", "one hold per frame", hold_cnt - h0, 1);
    chk("R1", "sleep after frame", sleep, 1);
    chk("R1", "oe off after frame", dout_oe, 0);
  endtask

  initial begin
    idle(5);
    @(negedge clk); rst = 1'b0;
    idle(3);
    cmp_on = 1'b1;
    chk("R1", "reset sleep", sleep, 1);
    chk("R1", "reset oe", dout_oe, 0);
    chk("R1", "reset dout", dout, 0);
    chk("R3", "reset hold", hold_strobe, 0);

    full_frame(14'h2A5C, 2'b10);
    full_frame(14'h3FFF, 2'b11);
    full_frame(14'h0000, 2'b01);
    full_frame(14'h1234, 2'b00);

    // R7: abort after 10 edges, then a clean frame
    begin
      logic [31:0] junk;
      int h0;
      h0 = hold_cnt;
      conv_word = 14'h0F0F; conv_sub = 2'b11;
      @(negedge clk); cs_n = 1'b0;
      idle(4);
      for (int i = 0; i < 10; i++) begin
        sclk = 1'b1; idle(HALF); sclk = 1'b0; idle(HALF);
      end
      cs_n = 1'b1;
      idle(4);
      chk("R7", "sleep after abort", sleep, 1);
      chk("R7", "oe off after abort", dout_oe, 0);
      chk("R7", "dout after abort", dout, 0);
      chk("R3", "hold before abort", hold_cnt - h0, 1);
      idle(MIN);
      read_frame(14'h1B3D, 2'b01, 24, junk);
      chk("R7", "frame after abort", int'(junk[23:0]), int'({8'h00, 14'h1B3D, 2'b01}));
    end

    // R8: select high for only 2 cycles is rejected
    begin
      int h0;
      @(negedge clk); cs_n = 1'b0;
      idle(8);
      cs_n = 1'b1;
      idle(2);
      cs_n = 1'b0;
      idle(8);
      chk("R8", "short high: oe", dout_oe, 0);
      chk("R8", "short high: sleep", sleep, 1);
      h0 = hold_cnt;
      for (int i = 0; i < 8; i++) begin
        sclk = 1'b1; idle(HALF); sclk = 1'b0; idle(HALF);
      end
      chk("R8", "short high: no hold", hold_cnt - h0, 0);
      chk("R8", "short high: still off", dout_oe, 0);
      cs_n = 1'b1;
      idle(MIN + 4);
      full_frame(14'h2C71, 2'b10);
    end

    idle(5);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule